// File: doc/BRIEF.md
# DRAM Activity Counter with Open-Row Tracking

This block watches the request stream going to a DRAM model and collects the activity figures needed for a later memory energy estimate. There are three figures: the number of reads, the number of writes, and the number of row activations. Each accepted request carries a byte address. The block splits that address into a column part, a bank index and a row index. The bank index sits directly above the column bits, so consecutive lines land in different banks.

The block assumes an open-page policy. Every bank keeps the row it last touched, or a "closed" marker after reset or clear. A request opens a row, and so counts as an activation, when its bank is closed or holds a different row. A request to the row that is already open is a row hit and adds no activation.

The live counters saturate and run in the background. Software reads them through a snapshot register set. A one-cycle snapshot pulse copies all three counters at the same clock edge, so the values read always belong together. A clear pulse resets the live counters and closes every bank.

Top module: `dram_activity_counter`

## Requirements
- R1: After reset, all three snapshot outputs read zero and every bank is closed, so the first access to any bank counts as an activation.
- R2: For address `a`, the bank index is `a[OFFSET_W+2:OFFSET_W]` and the row index is `a[OFFSET_W+16:OFFSET_W+3]`. The low OFFSET_W bits never change any count.
- R3: Each cycle with `req_valid` high and `req_write` low adds one to the read count.
- R4: Each cycle with `req_valid` high and `req_write` high adds one to the write count.
- R5: A valid request adds one activation when its bank is closed or its open row differs from the request row. A request to the open row adds none. After either case the bank holds the request row.
- R6: Banks are independent: a request changes the open row of its own bank only.
- R7: `clear` zeroes the three live counters and closes all banks. A request in the same cycle as `clear` is dropped. The snapshot outputs are not changed by `clear`.
- R8: Each counter stops at its all-ones value (2^CNT_W − 1) and never wraps.
- R9: A `snap` pulse copies the live counts, as they stood before that edge's update, into all three outputs together. The outputs then hold until the next `snap`.
- R10: Cycles with `req_valid` low change no counter and no open row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | OFFSET_W+BANK_W+ROW_W | Request byte address |
| clear | input | 1 | Zero the live counters and close all banks |
| snap | input | 1 | Copy the live counters to the outputs |
| rd_count | output | CNT_W | Read count, as of the last snapshot |
| wr_count | output | CNT_W | Write count, as of the last snapshot |
| act_count | output | CNT_W | Activation count, as of the last snapshot |

## Verification
A request or clear changes the live state at the rising edge where it is presented. That change becomes visible only through a snapshot. A snap driven before edge k shows the counts from all requests before edge k on the outputs right after edge k.

The bench drives every input on the falling edge. It pulses snap for one cycle and reads the outputs at the next falling edge. That way each check sees exactly the requests issued before the snap.

A second instance with 4-bit counters gets the same stimulus. It is compared against the saturated expected values.

// File: rtl/dram_activity_counter.sv
module dram_activity_counter #(
  parameter int OFFSET_W = 6,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14,
  parameter int CNT_W    = 48
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [OFFSET_W+BANK_W+ROW_W-1:0] req_addr,
  input  logic                            clear,
  input  logic                            snap,
  output logic [CNT_W-1:0]                rd_count,
  output logic [CNT_W-1:0]                wr_count,
  output logic [CNT_W-1:0]                act_count
);
  localparam int NBANK = 1 << BANK_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [ROW_W-1:0] open_row [NBANK];
  logic [NBANK-1:0] open_vld;
  logic [CNT_W-1:0] rd_live, wr_live, act_live;

  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic              unused_offset;
  logic              take, is_act;

  assign bank          = req_addr[OFFSET_W +: BANK_W];
  assign row           = req_addr[OFFSET_W+BANK_W +: ROW_W];
  assign unused_offset = ^req_addr[OFFSET_W-1:0];
  assign take          = req_valid && !clear;
  assign is_act        = !open_vld[bank] || (open_row[bank] != row);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      open_vld <= '0;
    end else if (take) begin
      open_vld[bank] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) open_row[i] <= '0;
    end else if (take) begin
      open_row[bank] <= row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_live  <= '0;
      wr_live  <= '0;
      act_live <= '0;
    end else if (take) begin
      if (!req_write && rd_live != CMAX) rd_live <= rd_live + 1'b1;
      if (req_write && wr_live != CMAX)  wr_live <= wr_live + 1'b1;
      if (is_act && act_live != CMAX)    act_live <= act_live + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_count  <= '0;
      wr_count  <= '0;
      act_count <= '0;
    end else if (snap) begin
      rd_count  <= rd_live;
      wr_count  <= wr_live;
      act_count <= act_live;
    end
  end
endmodule

module dram_activity_counter_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             clear,
  input logic             snap,
  input logic [CNT_W-1:0] rd_live,
  input logic [CNT_W-1:0] wr_live,
  input logic [CNT_W-1:0] act_live,
  input logic [CNT_W-1:0] rd_count,
  input logic [CNT_W-1:0] wr_count,
  input logic [CNT_W-1:0] act_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !clear && rd_live != CMAX) |=> rd_live == $past(rd_live) + 1'b1);

  a_r4_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !clear && wr_live != CMAX) |=> wr_live == $past(wr_live) + 1'b1);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !clear) |=> ($stable(rd_live) && $stable(wr_live) && $stable(act_live)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rd_live == '0 && wr_live == '0 && act_live == '0));

  a_r8_act_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (act_live == CMAX && !clear) |=> act_live == CMAX);

  a_r8_rd_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live == CMAX && !clear) |=> rd_live == CMAX);

  a_r9_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (rd_count == $past(rd_live) && wr_count == $past(wr_live) && act_count == $past(act_live)));

  a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> ($stable(rd_count) && $stable(wr_count) && $stable(act_count)));
endmodule

bind dram_activity_counter dram_activity_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .clear(clear), .snap(snap), .rd_live(rd_live), .wr_live(wr_live),
  .act_live(act_live), .rd_count(rd_count), .wr_count(wr_count),
  .act_count(act_count)
);

// File: tb/tb_dram_activity_counter.sv
module tb_dram_activity_counter;
  localparam int OW = 6;
  localparam int AW = OW + 3 + 14;

  logic clk = 0, rst_n = 0, req_valid = 0, req_write = 0, clear = 0, snap = 0;
  logic [AW-1:0] req_addr = '0;
  logic [47:0] rd_c, wr_c, act_c;
  logic [3:0]  rd_s, wr_s, act_s;

  always #5 clk = ~clk;

  dram_activity_counter #(.OFFSET_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .clear(clear), .snap(snap),
    .rd_count(rd_c), .wr_count(wr_c), .act_count(act_c));

  dram_activity_counter #(.OFFSET_W(OW), .CNT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .clear(clear), .snap(snap),
    .rd_count(rd_s), .wr_count(wr_s), .act_count(act_s));

  int checks = 0, errors = 0;
  longint e_rd, e_wr, e_act;
  bit     o_vld [8];
  int     o_row [8];

  function automatic longint sat4(longint v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    e_rd = 0; e_wr = 0; e_act = 0;
    for (int i = 0; i < 8; i++) begin o_vld[i] = 0; o_row[i] = 0; end
  endtask

  task automatic access(bit w, int bank, int row, int col);
    req_valid = 1; req_write = w;
    req_addr  = AW'({row[13:0], bank[2:0], col[OW-1:0]});
    if (w) e_wr++; else e_rd++;
    if (!o_vld[bank] || o_row[bank] != row) e_act++;
    o_vld[bank] = 1; o_row[bank] = row;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      req_write = i[0]; req_addr = AW'(i * 7919);
      @(negedge clk);
    end
    req_write = 0;
  endtask

  task automatic take_snap();
    snap = 1; @(negedge clk); snap = 0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " rd"},  rd_c,  e_rd);
    chk({tag, " wr"},  wr_c,  e_wr);
    chk({tag, " act"}, act_c, e_act);
    chk({tag, " rd sat R8"},  rd_s,  sat4(e_rd));
    chk({tag, " wr sat R8"},  wr_s,  sat4(e_wr));
    chk({tag, " act sat R8"}, act_s, sat4(e_act));
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R1/R5: first touch of every bank activates
    for (int b = 0; b < 8; b++) access(0, b, 100, 0);
    take_snap(); check_all("R1 R5 first touch");

    // R2/R5: same row, varying column bits -> hits only
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 4; c++) access(1, b, 100, c * 21);
    take_snap(); check_all("R2 R4 R5 column hits");

    // R6: change bank 3 only, others stay open on row 100
    access(0, 3, 16383, 0);
    for (int b = 0; b < 8; b++) access(0, b, 100, 5);
    take_snap(); check_all("R5 R6 bank independence");

    // R2 row extremes and a near-exhaustive mixed sweep
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 3; k++)
          access(k[0], b, (r == 3) ? 16383 : r * 4097, k * 9);
    take_snap(); check_all("R2 R3 R4 sweep");

    begin
      int s = 12345;
      for (int i = 0; i < 300; i++) begin
        s = s * 1103515245 + 12345;
        access(s[20], s[18:16], int'(s[25:23]) * 2047, int'(s[13:8]));
      end
    end
    take_snap(); check_all("R3 R4 R5 pseudo-random");

    // R10: idle cycles with junk on data inputs
    idle_junk(20);
    take_snap(); check_all("R10 idle");

    // R9: outputs hold without snap
    access(0, 0, 9, 0); access(1, 1, 9, 0);
    @(negedge clk);
    chk("R9 hold rd", rd_c, e_rd - 1);
    chk("R9 hold wr", wr_c, e_wr - 1);
    take_snap(); check_all("R9 after snap");

    // R7: clear with a simultaneous request; outputs untouched
    clear = 1; req_valid = 1; req_write = 1; req_addr = '0;
    @(negedge clk);
    clear = 0; req_valid = 0; req_write = 0;
    chk("R7 outputs unchanged by clear", rd_c, e_rd);
    model_reset();
    take_snap(); check_all("R7 cleared, request dropped");

    // R7: banks closed after clear -> revisiting row 9 reactivates
    access(0, 0, 9, 0);
    access(0, 0, 9, 1);
    take_snap(); check_all("R7 banks closed");

    // R9: snap and request in the same cycle captures pre-update value
    req_valid = 1; req_write = 0; req_addr = '0; snap = 1;
    @(negedge clk);
    req_valid = 0; snap = 0;
    chk("R9 snap pre-update rd", rd_c, e_rd);
    e_rd++; e_act++;
    take_snap(); check_all("R9 post");

    // R8: saturation on 4-bit instance
    for (int i = 0; i < 20; i++) access(1, 2, 77, 0);
    take_snap(); check_all("R8 saturation");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule